// File: doc/BRIEF.md
# Bus Hang Watchdog

This block sits beside a pipelined bus master and watches its outgoing cycle, strobe and acknowledge lines. While a bus cycle is open it counts clock edges on which nothing moves, meaning no new request strobe and no acknowledge. Any such movement, or the cycle line dropping, returns the count to its starting point. If the run of idle open-cycle edges reaches a fixed limit, the block emits a single-clock timeout pulse. That pulse is merged with the slave's own error input, so the master sees an ordinary bus error and can abandon the stuck transfer.

At the same edge that raises the pulse, the block saves the address that was on the bus. A minimal slave register port lets software fetch this saved address afterwards, zero-extended to 32 bits. The port always answers one clock after it is strobed. Writes are answered but change nothing. The limit is set by a parameter and software cannot alter it. A processor reset clears both the timer and the saved address.

Top module: `bus_hang_watchdog`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `timeout_o` and `reg_ack` are 0. A read issued after reset returns 0.
- R2: While `mon_cyc` is low, no timeout can occur, however long the bus stays idle.
- R3: An edge with `mon_cyc` high and either `mon_stb` or `mon_ack` high restarts the count. After it, a full LIMIT of further idle edges is needed before a timeout.
- R4: `timeout_o` is high for exactly the one clock that follows the LIMIT-th consecutive edge on which `mon_cyc`=1, `mon_stb`=0 and `mon_ack`=0.
- R5: `mst_err_o` equals `slv_err_i` OR `timeout_o` in every cycle, including when both are high together.
- R6: The value of `mon_addr` sampled on the edge that raises `timeout_o` is stored. It is held until the next timeout or reset.
- R7: A port access (`reg_cyc` and `reg_stb` high at an edge) is answered by `reg_ack`=1 in the following clock only. For a read (`reg_we`=0), `reg_rdata` then carries the stored address in its low ADDR_W bits, with the upper bits 0. A read sampled on the same edge as a capture returns the newly captured address.
- R8: A write (`reg_we`=1) is acknowledged with `reg_rdata`=0 and leaves the stored address unchanged. In any cycle without a read acknowledge, `reg_rdata` is 0.
- R9: `reg_stall` is always 0.
- R10: If the bus stays idle after a timeout, the next timeout comes only after a further LIMIT idle edges.
- R11: Asserting `rst` in the middle of a countdown discards the partial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Processor reset, active high, synchronous |
| mon_cyc | input | 1 | Monitored master's cycle line |
| mon_stb | input | 1 | Monitored master's request strobe |
| mon_ack | input | 1 | Acknowledge returned to the master |
| mon_addr | input | ADDR_W | Monitored master's address |
| slv_err_i | input | 1 | Error from the addressed slave |
| mst_err_o | output | 1 | Error delivered to the master |
| timeout_o | output | 1 | One-clock timeout pulse |
| reg_cyc | input | 1 | Register port cycle |
| reg_stb | input | 1 | Register port strobe |
| reg_we | input | 1 | Register port write enable |
| reg_ack | output | 1 | Register port acknowledge |
| reg_stall | output | 1 | Register port stall (always 0) |
| reg_rdata | output | 32 | Register port read data |

## Verification
Two things can fall on the same edge. The first is a software read of the saved address coinciding with the capture of a new one. The bench opens a bus cycle, leaves it idle for LIMIT-1 edges, and strobes the register port so that the read is sampled on the LIMIT-th idle edge. The acknowledged data must then already hold the newly captured address. The second is the slave error overlapping the timeout pulse. It is held high across that pulse, and the merged error must stay high with no gap or glitch. A behavioural model counts idle edges with an integer and is compared against every output on every clock.

// File: rtl/bhw_pkg.sv
package bhw_pkg;
    localparam int REG_DATA_W = 32;

    // One access seen on the register port, as sampled at an edge
    typedef struct packed {
        logic hit;
        logic rd;
    } bhw_access_t;
endpackage

// File: rtl/bhw_timer.sv
module bhw_timer #(
    parameter int CNT_W = 15,
    parameter int LIMIT = 'h2000
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    input  logic ack,
    output logic trip_now,
    output logic fire,
    output logic stall
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } tmr_t;

    tmr_t st_d, st_q;
    logic idle_edge;

    always_comb begin
        idle_edge = cyc && !stb && !ack;
        trip_now  = 1'b0;
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (!idle_edge) begin
            st_d.cnt = RELOAD;
        end else if (st_q.cnt <= CNT_W'(1)) begin
            st_d.cnt  = RELOAD;
            st_d.fire = 1'b1;
            trip_now  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= RELOAD;
            st_q.fire <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire  = st_q.fire;
    assign stall = 1'b0;
endmodule

// File: rtl/bhw_capture.sv
module bhw_capture
    import bhw_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trip_now,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  reg_cyc,
    input  logic                  reg_stb,
    input  logic                  reg_we,
    output logic                  reg_ack,
    output logic [REG_DATA_W-1:0] reg_rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] hold;
        bhw_access_t       acc;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.acc.hit = reg_cyc && reg_stb;
        st_d.acc.rd  = reg_cyc && reg_stb && !reg_we;
        if (trip_now) begin
            st_d.hold = addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_ack   = st_q.acc.hit;
    assign reg_rdata = st_q.acc.rd ? REG_DATA_W'(st_q.hold) : '0;
endmodule

// File: rtl/bus_hang_watchdog.sv
module bus_hang_watchdog #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 15,
    parameter int LIMIT  = 'h2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_cyc,
    input  logic              mon_stb,
    input  logic              mon_ack,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              slv_err_i,
    output logic              mst_err_o,
    output logic              timeout_o,
    input  logic              reg_cyc,
    input  logic              reg_stb,
    input  logic              reg_we,
    output logic              reg_ack,
    output logic              reg_stall,
    output logic [31:0]       reg_rdata
);
    logic trip_now;

    bhw_timer #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .cyc      (mon_cyc),
        .stb      (mon_stb),
        .ack      (mon_ack),
        .trip_now (trip_now),
        .fire     (timeout_o),
        .stall    (reg_stall)
    );

    bhw_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .trip_now  (trip_now),
        .addr      (mon_addr),
        .reg_cyc   (reg_cyc),
        .reg_stb   (reg_stb),
        .reg_we    (reg_we),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata)
    );

    assign mst_err_o = slv_err_i | timeout_o;
endmodule

// File: rtl/bhw_checker.sv
module bhw_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              mon_cyc,
    input logic              mon_stb,
    input logic              mon_ack,
    input logic [ADDR_W-1:0] mon_addr,
    input logic              slv_err_i,
    input logic              mst_err_o,
    input logic              timeout_o,
    input logic              reg_cyc,
    input logic              reg_stb,
    input logic              reg_we,
    input logic              reg_ack,
    input logic              reg_stall,
    input logic [31:0]       reg_rdata
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !mon_cyc |=> !timeout_o);

    p_progress_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (mon_cyc && (mon_stb || mon_ack)) |=> !timeout_o);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    p_err_from_timeout_r5: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> mst_err_o);

    p_err_from_slave_r5: assert property (@(posedge clk) disable iff (rst)
        slv_err_i |-> mst_err_o);

    p_ack_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_cyc && reg_stb) |=> reg_ack);

    p_ack_caused_r7: assert property (@(posedge clk) disable iff (rst)
        !(reg_cyc && reg_stb) |=> !reg_ack);

    p_write_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_cyc && reg_stb && reg_we) |=> (reg_rdata == 32'h0));

    p_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_stall);
endmodule

bind bus_hang_watchdog bhw_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bus_hang_watchdog_bench.sv
module bus_hang_watchdog_bench;
    localparam int AW  = 24;
    localparam int LIM = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          cyc = 0, stb = 0, ack = 0, serr = 0;
    logic          rcyc = 0, rstb = 0, rwe = 0;
    logic [AW-1:0] addr = '0;
    logic          err_o, to_o, r_ack, r_stall;
    logic [31:0]   r_data;

    bus_hang_watchdog #(.ADDR_W(AW), .CNT_W(15), .LIMIT(LIM)) u_bus_hang_watchdog (
        .clk(clk), .rst(rst), .mon_cyc(cyc), .mon_stb(stb), .mon_ack(ack),
        .mon_addr(addr), .slv_err_i(serr), .mst_err_o(err_o), .timeout_o(to_o),
        .reg_cyc(rcyc), .reg_stb(rstb), .reg_we(rwe), .reg_ack(r_ack),
        .reg_stall(r_stall), .reg_rdata(r_data)
    );

    int total = 0, bad = 0;
    bit started = 0, finished = 0;
    string cur_tag = "R1";

    // behavioural reference
    int            quiet = 0;
    bit            m_to = 0, m_ack = 0, m_rd = 0;
    logic [AW-1:0] m_hold = '0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            quiet = 0; m_to = 0; m_hold = '0; m_ack = 0; m_rd = 0;
        end else begin
            if (cyc && !stb && !ack) begin
                quiet = quiet + 1;
                if (quiet == LIM) begin
                    m_to = 1; quiet = 0; m_hold = addr;
                end else begin
                    m_to = 0;
                end
            end else begin
                quiet = 0; m_to = 0;
            end
            m_ack = rcyc && rstb;
            m_rd  = rcyc && rstb && !rwe;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk(cur_tag, "timeout", {31'b0, to_o}, {31'b0, m_to});
            chk("R5", "mst_err", {31'b0, err_o}, {31'b0, serr | m_to});
            chk(cur_tag, "reg_ack", {31'b0, r_ack}, {31'b0, m_ack});
            chk(cur_tag, "reg_rdata", r_data, m_rd ? 32'(m_hold) : 32'h0);
            chk("R9", "reg_stall", {31'b0, r_stall}, 32'h0);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            addr = addr + 24'h000101;
        end
    endtask

    task automatic reg_op(input bit we, input int n);
        rcyc = 1; rstb = 1; rwe = we;
        wait_cyc(n);
        rcyc = 0; rstb = 0; rwe = 0;
    endtask

    initial begin
        cur_tag = "R1";
        wait_cyc(3);
        rst = 0;
        reg_op(0, 1);
        wait_cyc(2);

        cur_tag = "R2";
        cyc = 0;
        wait_cyc(3 * LIM);

        cur_tag = "R3";
        cyc = 1;
        for (int k = 0; k < 3; k++) begin
            stb = 0; wait_cyc(LIM - 1);
            stb = 1; wait_cyc(1);
        end
        stb = 0;
        for (int k = 0; k < 3; k++) begin
            ack = 0; wait_cyc(LIM - 1);
            ack = 1; wait_cyc(1);
        end
        ack = 0; cyc = 0;
        wait_cyc(2);

        cur_tag = "R4";
        cyc = 1;
        wait_cyc(LIM + 1);
        cur_tag = "R6";
        reg_op(0, 1);
        wait_cyc(1);
        cur_tag = "R10";
        wait_cyc(LIM + 2);
        cyc = 0;
        wait_cyc(2);

        cur_tag = "R5";
        cyc = 1;
        wait_cyc(LIM - 2);
        serr = 1;
        wait_cyc(4);
        serr = 0;
        cyc = 0;
        wait_cyc(2);

        cur_tag = "R7";
        cyc = 1;
        wait_cyc(LIM - 1);
        reg_op(0, 1);
        cyc = 0;
        reg_op(0, 2);
        wait_cyc(2);

        cur_tag = "R8";
        reg_op(1, 3);
        wait_cyc(1);
        reg_op(0, 1);
        wait_cyc(2);

        cur_tag = "R11";
        cyc = 1;
        wait_cyc(LIM - 2);
        rst = 1;
        wait_cyc(2);
        rst = 0;
        wait_cyc(LIM - 1);
        wait_cyc(3);
        cyc = 0;
        cur_tag = "R1";
        reg_op(0, 1);
        wait_cyc(2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule